// File: doc/BRIEF.md
# Policy-Selectable Register Field Cell

This block is a single software-visible register field. A parameter fixes, at elaboration, the policy that governs what a bus write and a bus read do to the stored bits. Policies cover plain storage, read-only status, constants and reserved bits. They also cover whole-field set or clear on write, per-bit actions keyed on written ones or zeros, clear or set on read, write-once, write-only with a read error, one-cycle pulse outputs, and two orderings of a hardware load against a software write.

A register bank places one cell per field. It drives the cell with an address-hit qualifier, a write strobe with its data slice, and a read strobe. It collects the read data slice and the read error flag. The field contents appear on `value` for the logic the register controls. The pulse policies deliver their one-cycle strobes on `pulse`.

A bus access acts only when `hit` is high. When a write and a read reach the field in the same cycle, the read returns the value held before that cycle, the write action is applied, and no read side effect occurs.

Top module: `rfc_field_cell`

## Requirements
- R1: Reset loads RST_VAL into every stateful policy. The constant policy (encoding 2) always shows RST_VAL on `value` and ignores writes.
- R2: Plain storage (encoding 0) stores write data as-is, and reads have no side effect. `rd_data` carries the field value during a hit read and is 0 otherwise.
- R3: Read-only (encoding 1) shows `hw_val` and ignores writes. Reserved (encoding 3) reads 0 and ignores writes.
- R4: Clear-on-read (4) and set-on-read (5) ignore writes, and a read forces all bits to 0 or to 1. Store-then-clear-on-read (6) and store-then-set-on-read (7) take write data as-is and clear or set all bits on a read.
- R5: Write-clear (8) forces all bits to 0 and write-set (9) forces all bits to 1, whatever the data. Write-set/read-clear (10) and write-clear/read-set (11) add the opposite read action.
- R6: Per-bit policies change only the bits whose written value equals the key. Encodings 12, 13 and 14 clear, set and toggle the bits written as 1. Encodings 15, 16 and 17 clear, set and toggle the bits written as 0.
- R7: Encodings 18 (ones set, read clears), 19 (ones clear, read sets), 20 (zeros set, read clears) and 21 (zeros clear, read sets) combine a per-bit write with a whole-field read action.
- R8: Write-only as-is (22), write-only clear (23) and write-only set (24) write like their readable counterparts. A hit read of them raises `rd_err` and returns 0.
- R9: Write-once (25) and write-once-write-only (26) accept only the first write after reset. Encoding 26 also raises `rd_err` on a hit read.
- R10: Pulse-on-one (27) and pulse-on-zero (28) hold no state and read 0. In the cycle after a hit write, `pulse` is high for exactly the bits written 1 (or 0 for 28), and 0 otherwise.
- R11: Hardware-first (29) loads `hw_val` on `hw_set`, winning over a simultaneous write. Software-first (30) lets the write win over `hw_set`. Neither has a read side effect.
- R12: With a same-cycle write and read, the write action takes effect and the read side effect is dropped. Without `hit`, strobes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit | input | 1 | Address decode selects this field |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data slice |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Read data slice, 0 unless a readable hit read |
| rd_err | output | 1 | Read of a write-only policy |
| hw_set | input | 1 | Hardware load enable (policies 29, 30) |
| hw_val | input | WIDTH | Hardware load value / read-only source |
| value | output | WIDTH | Current field contents |
| pulse | output | WIDTH | One-cycle per-bit strobes (policies 27, 28) |

## Verification
A wrong stored value is visible on `value` at the first sampling point after the clock edge that produced it. It also appears on `rd_data` during the next hit read. A wrong write-once flag shows up as a later write that is taken, or as a first write that is dropped, one cycle after that write. A misapplied read side effect or a wrong collision priority is visible on `value` one cycle after the colliding access. Every policy is instantiated side by side under the same stimulus, so a fault is seen in the same cycle on whichever policies it affects.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

   typedef enum logic [4:0] {
      P_RW          = 5'd0,
      P_RO          = 5'd1,
      P_CONST       = 5'd2,
      P_RSV         = 5'd3,
      P_RDCLR       = 5'd4,
      P_RDSET       = 5'd5,
      P_WR_RDCLR    = 5'd6,
      P_WR_RDSET    = 5'd7,
      P_WCLR        = 5'd8,
      P_WSET        = 5'd9,
      P_WSET_RDCLR  = 5'd10,
      P_WCLR_RDSET  = 5'd11,
      P_B1CLR       = 5'd12,
      P_B1SET       = 5'd13,
      P_B1TGL       = 5'd14,
      P_B0CLR       = 5'd15,
      P_B0SET       = 5'd16,
      P_B0TGL       = 5'd17,
      P_B1SET_RDCLR = 5'd18,
      P_B1CLR_RDSET = 5'd19,
      P_B0SET_RDCLR = 5'd20,
      P_B0CLR_RDSET = 5'd21,
      P_WO          = 5'd22,
      P_WO_CLR      = 5'd23,
      P_WO_SET      = 5'd24,
      P_ONCE        = 5'd25,
      P_ONCE_WO     = 5'd26,
      P_PULSE1      = 5'd27,
      P_PULSE0      = 5'd28,
      P_HW_WINS     = 5'd29,
      P_SW_WINS     = 5'd30
   } pol_e;

   localparam int NUM_POL = 31;

   typedef enum logic [1:0] {RD_NONE, RD_CLEAR, RD_SET} rd_act_e;

   function automatic rd_act_e rd_action(pol_e p);
      case (p)
         P_RDCLR, P_WR_RDCLR, P_WSET_RDCLR,
         P_B1SET_RDCLR, P_B0SET_RDCLR:      return RD_CLEAR;
         P_RDSET, P_WR_RDSET, P_WCLR_RDSET,
         P_B1CLR_RDSET, P_B0CLR_RDSET:      return RD_SET;
         default:                           return RD_NONE;
      endcase
   endfunction

   function automatic bit rd_is_error(pol_e p);
      return p inside {P_WO, P_WO_CLR, P_WO_SET, P_ONCE_WO};
   endfunction

   function automatic bit no_storage(pol_e p);
      return p inside {P_RO, P_CONST, P_RSV, P_PULSE1, P_PULSE0};
   endfunction

   function automatic bit is_once(pol_e p);
      return p inside {P_ONCE, P_ONCE_WO};
   endfunction

   function automatic bit is_pulse(pol_e p);
      return p inside {P_PULSE1, P_PULSE0};
   endfunction

   function automatic bit is_hw(pol_e p);
      return p inside {P_HW_WINS, P_SW_WINS};
   endfunction

endpackage

// File: rtl/rfc_wr_calc.sv
module rfc_wr_calc
   import rfc_pkg::*;
#(
   parameter int   WIDTH = 8,
   parameter pol_e POL   = P_RW
)(
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] nxt
);

   always_comb begin
      case (POL)
         P_RW, P_WR_RDCLR, P_WR_RDSET, P_WO,
         P_ONCE, P_ONCE_WO, P_HW_WINS, P_SW_WINS:  nxt = wdata;
         P_WCLR, P_WO_CLR, P_WCLR_RDSET:           nxt = '0;
         P_WSET, P_WO_SET, P_WSET_RDCLR:           nxt = '1;
         P_B1CLR, P_B1CLR_RDSET:                   nxt = cur & ~wdata;
         P_B1SET, P_B1SET_RDCLR:                   nxt = cur | wdata;
         P_B1TGL:                                  nxt = cur ^ wdata;
         P_B0CLR, P_B0CLR_RDSET:                   nxt = cur & wdata;
         P_B0SET, P_B0SET_RDCLR:                   nxt = cur | ~wdata;
         P_B0TGL:                                  nxt = cur ^ ~wdata;
         default:                                  nxt = cur;
      endcase
   end

endmodule

// File: rtl/rfc_rd_calc.sv
module rfc_rd_calc
   import rfc_pkg::*;
#(
   parameter int   WIDTH = 8,
   parameter pol_e POL   = P_RW
)(
   input  logic             rd_fire,
   input  logic             wr_fire,
   output logic             apply,
   output logic [WIDTH-1:0] nxt
);

   localparam rd_act_e ACT = rd_action(POL);

   // a write in the same cycle suppresses the read action
   assign apply = rd_fire && !wr_fire && (ACT != RD_NONE);
   assign nxt   = (ACT == RD_SET) ? '1 : '0;

endmodule

// File: rtl/rfc_field_cell.sv
module rfc_field_cell
   import rfc_pkg::*;
#(
   parameter int               WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0,
   parameter pol_e             POLICY  = P_HW_WINS
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_err,
   input  logic             hw_set,
   input  logic [WIDTH-1:0] hw_val,
   output logic [WIDTH-1:0] value,
   output logic [WIDTH-1:0] pulse
);

   localparam bit      WIRE_ONLY = no_storage(POLICY);
   localparam bit      ONCE      = is_once(POLICY);
   localparam bit      HWV       = is_hw(POLICY);
   localparam bit      ERR_RD    = rd_is_error(POLICY);
   localparam rd_act_e RACT      = rd_action(POLICY);

   if (WIDTH < 1) begin : g_chk_w
      $error("rfc_field_cell: WIDTH must be at least 1");
   end
   if (POLICY == P_RSV && RST_VAL != '0) begin : g_chk_rsv
      $error("rfc_field_cell: reserved field needs a zero reset value");
   end

   logic             wr_fire, rd_fire;
   logic [WIDTH-1:0] value_q, pulse_q, wnxt, rnxt;
   logic             rapply;

   assign wr_fire = hit && wr_en;
   assign rd_fire = hit && rd_en;

   rfc_wr_calc #(.WIDTH(WIDTH), .POL(POLICY)) u_wr (
      .cur   (value_q),
      .wdata (wr_data),
      .nxt   (wnxt)
   );

   rfc_rd_calc #(.WIDTH(WIDTH), .POL(POLICY)) u_rd (
      .rd_fire (rd_fire),
      .wr_fire (wr_fire),
      .apply   (rapply),
      .nxt     (rnxt)
   );

   if (WIRE_ONLY) begin : g_wire
      if (POLICY == P_RO) begin : g_ro
         assign value_q = hw_val;
      end else if (POLICY == P_CONST) begin : g_const
         assign value_q = RST_VAL;
      end else begin : g_zero
         assign value_q = '0;
      end

      if (is_pulse(POLICY)) begin : g_pulse
         logic [WIDTH-1:0] key;
         assign key = (POLICY == P_PULSE1) ? wr_data : ~wr_data;
         always_ff @(posedge clk) begin
            if (!rst_n)       pulse_q <= '0;
            else if (wr_fire) pulse_q <= key;
            else              pulse_q <= '0;
         end
         AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (|pulse_q) |-> $past(hit && wr_en)); // R10
      end else begin : g_nopulse
         assign pulse_q = '0;
      end
   end else begin : g_reg
      logic armed;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            value_q <= RST_VAL;
            armed   <= 1'b1;
         end else begin
            if (POLICY == P_HW_WINS) begin
               if (hw_set)       value_q <= hw_val;
               else if (wr_fire) value_q <= wnxt;
            end else if (POLICY == P_SW_WINS) begin
               if (wr_fire)      value_q <= wnxt;
               else if (hw_set)  value_q <= hw_val;
            end else if (wr_fire) begin
               if (!ONCE || armed) value_q <= wnxt;
            end else if (rapply) begin
               value_q <= rnxt;
            end
            if (wr_fire) armed <= 1'b0;
         end
      end

      assign pulse_q = '0;

      AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_fire && !rd_fire && !(HWV && hw_set)) |=> $stable(value_q)); // R12

      if (RACT == RD_CLEAR) begin : g_a_clr
         AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_fire && !wr_fire) |=> (value_q == '0)); // R4
      end
      if (RACT == RD_SET) begin : g_a_set
         AST_READ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_fire && !wr_fire) |=> (value_q == '1)); // R4
      end
      if (ONCE) begin : g_a_once
         AST_ONCE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed && wr_fire) |=> $stable(value_q)); // R9
      end
      if (POLICY == P_HW_WINS) begin : g_a_hw
         AST_HW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set |=> (value_q == $past(hw_val))); // R11
      end
      if (POLICY == P_SW_WINS) begin : g_a_sw
         AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && wr_en) |=> (value_q == $past(wr_data))); // R11
      end
   end

   assign value   = value_q;
   assign pulse   = pulse_q;
   assign rd_data = (rd_fire && !ERR_RD) ? value_q : '0;
   assign rd_err  = rd_fire && ERR_RD;

   AST_ERR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (hit && rd_en)); // R8

endmodule

// File: tb/tb_rfc_field_cell.sv
`timescale 1ns/1ps
module tb_rfc_field_cell;
   import rfc_pkg::*;

   localparam int         W   = 8;
   localparam logic [W-1:0] RST = 8'hA5;
   localparam int         NP  = NUM_POL;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst_n, hit, wr_en, rd_en, hw_set;
   logic [W-1:0] wr_data, hw_val;

   logic [W-1:0] val_a [NP];
   logic [W-1:0] rdd_a [NP];
   logic [W-1:0] pul_a [NP];
   logic         err_a [NP];

   for (genvar i = 0; i < NP; i++) begin : g
      rfc_field_cell #(.WIDTH(W), .RST_VAL((i == 3) ? '0 : RST), .POLICY(pol_e'(i))) dut (
         .clk(clk), .rst_n(rst_n), .hit(hit), .wr_en(wr_en), .wr_data(wr_data),
         .rd_en(rd_en), .rd_data(rdd_a[i]), .rd_err(err_a[i]), .hw_set(hw_set),
         .hw_val(hw_val), .value(val_a[i]), .pulse(pul_a[i]));
   end

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [W-1:0] m_q [NP];
   logic [W-1:0] m_p [NP];
   bit           m_armed [NP];

   function automatic string req_of(int p);
      case (p)
         0: return "R2";
         1, 3: return "R3";
         2: return "R1";
         4, 5, 6, 7: return "R4";
         8, 9, 10, 11: return "R5";
         12, 13, 14, 15, 16, 17: return "R6";
         18, 19, 20, 21: return "R7";
         22, 23, 24: return "R8";
         25, 26: return "R9";
         27, 28: return "R10";
         default: return "R11";
      endcase
   endfunction

   function automatic bit wo(int p);
      return p == 22 || p == 23 || p == 24 || p == 26;
   endfunction

   // 0 none, 1 clear on read, 2 set on read
   function automatic int rkind(int p);
      if (p == 4 || p == 6 || p == 10 || p == 18 || p == 20) return 1;
      if (p == 5 || p == 7 || p == 11 || p == 19 || p == 21) return 2;
      return 0;
   endfunction

   function automatic logic [W-1:0] wr_model(int p, logic [W-1:0] c, logic [W-1:0] d);
      case (p)
         0, 6, 7, 22:      return d;
         8, 11, 23:        return '0;
         9, 10, 24:        return '1;
         12, 19:           return c & ~d;
         13, 18:           return c | d;
         14:               return c ^ d;
         15, 21:           return c & d;
         16, 20:           return c | ~d;
         17:               return c ^ ~d;
         default:          return c;
      endcase
   endfunction

   function automatic logic [W-1:0] shown(int p);
      if (p == 1) return hw_val;
      return m_q[p];
   endfunction

   task automatic chk(bit ok, string r, string what, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int p = 0; p < NP; p++) begin
         m_q[p] = (p == 3 || p == 27 || p == 28) ? '0 : RST;
         m_p[p] = '0;
         m_armed[p] = 1'b1;
      end
   endtask

   task automatic check_state();
      for (int p = 0; p < NP; p++) begin
         chk(val_a[p] === shown(p), req_of(p), $sformatf("value pol=%0d", p), val_a[p], shown(p));
         chk(pul_a[p] === m_p[p], req_of(p), $sformatf("pulse pol=%0d", p), pul_a[p], m_p[p]);
      end
   endtask

   // called at a falling edge: check state, drive, check read path, advance model
   task automatic step(bit h, bit we, logic [W-1:0] wd, bit re, bit hs, logic [W-1:0] hv);
      bit wf, rf;
      check_state();
      hit = h; wr_en = we; wr_data = wd; rd_en = re; hw_set = hs; hw_val = hv;
      #1;
      wf = h && we;
      rf = h && re;
      for (int p = 0; p < NP; p++) begin
         logic [W-1:0] er;
         er = (rf && !wo(p)) ? shown(p) : '0;
         chk(rdd_a[p] === er, req_of(p), $sformatf("rd_data pol=%0d", p), rdd_a[p], er);
         chk(err_a[p] === (rf && wo(p)), wo(p) ? "R8" : req_of(p),
             $sformatf("rd_err pol=%0d", p), W'(err_a[p]), W'(rf && wo(p)));
      end
      for (int p = 0; p < NP; p++) begin
         case (p)
            1, 2, 3: ;
            27: m_p[p] = wf ? wd : '0;
            28: m_p[p] = wf ? ~wd : '0;
            29: begin
               if (hs) m_q[p] = hv;
               else if (wf) m_q[p] = wd;
            end
            30: begin
               if (wf) m_q[p] = wd;
               else if (hs) m_q[p] = hv;
            end
            25, 26: begin
               if (wf && m_armed[p]) m_q[p] = wd;
               if (wf) m_armed[p] = 1'b0;
            end
            default: begin
               if (wf) m_q[p] = wr_model(p, m_q[p], wd);
               else if (rf && rkind(p) == 1) m_q[p] = '0;
               else if (rf && rkind(p) == 2) m_q[p] = '1;
            end
         endcase
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; hit = 0; wr_en = 0; rd_en = 0; hw_set = 0; wr_data = '0; hw_val = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      // R1: reset values checked by the first state check
      // R12: strobes without hit change nothing
      step(1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 8'h00);
      chk(val_a[4] === RST, "R12", "no-hit read on clear-on-read", val_a[4], RST);
      chk(val_a[0] === RST, "R12", "no-hit write on plain", val_a[0], RST);
      // R12: same-cycle write and read, write wins, no read effect
      step(1'b1, 1'b1, 8'h3C, 1'b1, 1'b0, 8'h00);
      chk(val_a[4] === RST, "R12", "collision on clear-on-read", val_a[4], RST);
      chk(val_a[6] === 8'h3C, "R12", "collision on store-clear-on-read", val_a[6], 8'h3C);
      chk(val_a[25] === 8'h3C, "R9", "first write taken", val_a[25], 8'h3C);
      // R9: later write ignored
      step(1'b1, 1'b1, 8'h0F, 1'b0, 1'b0, 8'h00);
      chk(val_a[25] === 8'h3C, "R9", "second write ignored", val_a[25], 8'h3C);
      chk(pul_a[27] === 8'h0F, "R10", "pulse on ones", pul_a[27], 8'h0F);
      chk(pul_a[28] === 8'hF0, "R10", "pulse on zeros", pul_a[28], 8'hF0);
      // R11: simultaneous hardware load and write
      step(1'b1, 1'b1, 8'h11, 1'b0, 1'b1, 8'h99);
      chk(val_a[29] === 8'h99, "R11", "hardware wins", val_a[29], 8'h99);
      chk(val_a[30] === 8'h11, "R11", "software wins", val_a[30], 8'h11);
      // R5: whole-field write set/clear
      chk(val_a[8] === 8'h00, "R5", "write clears", val_a[8], 8'h00);
      chk(val_a[9] === 8'hFF, "R5", "write sets", val_a[9], 8'hFF);
      for (int n = 0; n < 3000; n++) begin
         step(($urandom % 4) != 0, ($urandom % 5) < 2, W'($urandom), ($urandom % 5) < 2,
              ($urandom % 4) == 0, W'($urandom));
      end
      check_state();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule